// File: doc/BRIEF.md
# ECAM Configuration Access Decoder

This block sits behind a memory-mapped configuration window. A processor access into that window carries a bus, device, function and register offset packed into its address. The decoder unpacks those fields and emits a configuration request descriptor one clock later. The descriptor says whether the request goes to the directly attached bus or further downstream, and whether it can be issued at all.

The window actually built into the address map may be much smaller than the 256 MB that a full bus range needs. To cover this, the bus number can be supplied wholly or partly by a programmed target-bus value instead of the address. A per-bit mask selects, for each bit, whether it comes from the register or from the address. Software programs the target bus before each run of accesses to a new bus. It also programs the secondary and subordinate bus numbers that bound the hierarchy reachable through the port. All four values are written through a small register write port.

Top module: `ecam_cfg_decoder`

## Requirements
- R1: After reset the target bus is 0, the mask is 0xFF, and the secondary and subordinate buses are 0; req_valid is low.
- R2: An access with acc_valid high produces req_valid high on the next clock only. That request carries device = addr[19:15], function = addr[14:12], register = addr[11:0] and the access's write flag.
- R3: The bus is computed bit by bit as (target AND mask) OR (addr[27:20] AND NOT mask). A mask bit of 1 takes the register bit and a mask bit of 0 takes the address bit.
- R4: reg_wr_sel selects the register a write lands in: 0 target bus, 1 mask, 2 secondary, 3 subordinate. A write is seen by accesses from the following cycle onward. An access in the same cycle as the write uses the old value, and a register keeps its value until it is written again.
- R5: A request whose bus equals the secondary bus is type 0, reported as req_type 4.
- R6: A request whose bus is above the secondary bus and not above the subordinate bus is type 1, reported as req_type 5, and is supported.
- R7: Any other bus is reported with req_type 5 and req_unsupported high.
- R8: A type 0 request to a nonzero device number has req_unsupported high. A type 0 request to device 0 has it low.
- R9: req_misaligned is high exactly when all four byte enables are set and addr[1:0] is nonzero.
- R10: With the subordinate bus set to 255, bus 255 is reachable as type 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Bus register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 target, 1 mask, 2 secondary, 3 subordinate |
| reg_wr_data | input | 8 | Write data |
| acc_valid | input | 1 | Access into the configuration window |
| acc_addr | input | 28 | Offset of the access within the window |
| acc_be | input | 4 | Byte enables |
| acc_write | input | 1 | 1 = write, 0 = read |
| req_valid | output | 1 | Descriptor valid |
| req_write | output | 1 | Request is a write |
| req_bus | output | 8 | Effective bus number |
| req_dev | output | 5 | Device number |
| req_func | output | 3 | Function number |
| req_reg | output | 12 | Register byte offset |
| req_type | output | 5 | Request type code, 4 = type 0, 5 = type 1 |
| req_unsupported | output | 1 | Request cannot be issued |
| req_misaligned | output | 1 | Full-dword access at an unaligned offset |

## Verification
Accesses are run with the mask at all ones, all zeros and mixed patterns. These show whether each bus bit follows the register or the address. Buses are placed below, at, just above, inside and beyond the secondary/subordinate range, so each edge of the type decision is separated, and register writes are made in the same cycle as accesses to show when a write takes effect. Device numbers and byte-enable/offset pairs are varied to separate the type 0 device rule and the alignment rule from the bus routing.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFS_W  = 12;
    localparam int BE_W   = 4;
    localparam int SEL_W  = 2;
    localparam int TYPE_W = 5;

    localparam int FN_LSB  = OFS_W;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;
    localparam int ADDR_W  = BUS_LSB + BUS_W;

    localparam logic [TYPE_W-1:0] TLP_CFG_T0 = TYPE_W'(4);
    localparam logic [TYPE_W-1:0] TLP_CFG_T1 = TYPE_W'(5);

    typedef enum logic [SEL_W-1:0] {
        SEL_TARGET    = 2'd0,
        SEL_MASK      = 2'd1,
        SEL_SECONDARY = 2'd2,
        SEL_SUBORD    = 2'd3
    } bus_reg_sel_e;

    typedef struct packed {
        logic [BUS_W-1:0] target;
        logic [BUS_W-1:0] mask;
        logic [BUS_W-1:0] secondary;
        logic [BUS_W-1:0] subord;
    } bus_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   func;
        logic [OFS_W-1:0]  ofs;
        logic [TYPE_W-1:0] type_code;
        logic              unsupported;
        logic              misaligned;
    } cfg_req_t;

    localparam bus_cfg_t BUS_CFG_RESET = '{
        target:    '0,
        mask:      '1,
        secondary: '0,
        subord:    '0
    };

    function automatic logic full_dword_unaligned(
        input logic [BE_W-1:0]  be,
        input logic [OFS_W-1:0] ofs
    );
        return (&be) && (ofs[1:0] != 2'b00);
    endfunction

endpackage

// File: rtl/ecam_bus_regs.sv
module ecam_bus_regs
    import ecam_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    output bus_cfg_t         cfg_q
);

    bus_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (bus_reg_sel_e'(wr_sel))
                SEL_TARGET:    cfg_d.target    = wr_data;
                SEL_MASK:      cfg_d.mask      = wr_data;
                SEL_SECONDARY: cfg_d.secondary = wr_data;
                SEL_SUBORD:    cfg_d.subord    = wr_data;
                default:       cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= BUS_CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/ecam_bus_merge.sv
module ecam_bus_merge
    import ecam_pkg::*;
#(
    parameter int WIDTH = BUS_W
) (
    input  logic [WIDTH-1:0] reg_bus,
    input  logic [WIDTH-1:0] sel_reg,
    input  logic [WIDTH-1:0] addr_bus,
    output logic [WIDTH-1:0] eff_bus
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign eff_bus[b] = sel_reg[b] ? reg_bus[b] : addr_bus[b];
    end

endmodule

// File: rtl/ecam_route_classify.sv
module ecam_route_classify
    import ecam_pkg::*;
(
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [BUS_W-1:0]  secondary,
    input  logic [BUS_W-1:0]  subord,
    output logic [TYPE_W-1:0] type_code,
    output logic              unsupported
);

    logic local_hit;
    logic downstream_hit;

    always_comb begin
        local_hit      = (bus == secondary);
        downstream_hit = (bus > secondary) && (bus <= subord);
        if (local_hit) begin
            type_code   = TLP_CFG_T0;
            unsupported = (dev != '0);
        end else begin
            type_code   = TLP_CFG_T1;
            unsupported = !downstream_hit;
        end
    end

endmodule

// File: rtl/ecam_cfg_decoder.sv
module ecam_cfg_decoder
    import ecam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_wr_sel,
    input  logic [BUS_W-1:0]  reg_wr_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BE_W-1:0]   acc_be,
    input  logic              acc_write,
    output logic              req_valid,
    output logic              req_write,
    output logic [BUS_W-1:0]  req_bus,
    output logic [DEV_W-1:0]  req_dev,
    output logic [FN_W-1:0]   req_func,
    output logic [OFS_W-1:0]  req_reg,
    output logic [TYPE_W-1:0] req_type,
    output logic              req_unsupported,
    output logic              req_misaligned
);

    bus_cfg_t          cfg_q;
    logic [BUS_W-1:0]  eff_bus;
    logic [DEV_W-1:0]  acc_dev;
    logic [TYPE_W-1:0] cls_type;
    logic              cls_unsup;
    cfg_req_t          req_d;
    cfg_req_t          req_q;

    assign acc_dev = acc_addr[DEV_LSB +: DEV_W];

    ecam_bus_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .cfg_q   (cfg_q)
    );

    ecam_bus_merge #(.WIDTH(BUS_W)) u_merge (
        .reg_bus  (cfg_q.target),
        .sel_reg  (cfg_q.mask),
        .addr_bus (acc_addr[BUS_LSB +: BUS_W]),
        .eff_bus  (eff_bus)
    );

    ecam_route_classify u_class (
        .bus         (eff_bus),
        .dev         (acc_dev),
        .secondary   (cfg_q.secondary),
        .subord      (cfg_q.subord),
        .type_code   (cls_type),
        .unsupported (cls_unsup)
    );

    always_comb begin
        req_d.valid       = acc_valid;
        req_d.write       = acc_write;
        req_d.bus         = eff_bus;
        req_d.dev         = acc_dev;
        req_d.func        = acc_addr[FN_LSB +: FN_W];
        req_d.ofs         = acc_addr[OFS_W-1:0];
        req_d.type_code   = cls_type;
        req_d.unsupported = cls_unsup;
        req_d.misaligned  = full_dword_unaligned(acc_be, acc_addr[OFS_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_valid       = req_q.valid;
    assign req_write       = req_q.write;
    assign req_bus         = req_q.bus;
    assign req_dev         = req_q.dev;
    assign req_func        = req_q.func;
    assign req_reg         = req_q.ofs;
    assign req_type        = req_q.type_code;
    assign req_unsupported = req_q.unsupported;
    assign req_misaligned  = req_q.misaligned;

endmodule

// File: rtl/ecam_cfg_checker.sv
module ecam_cfg_checker
    import ecam_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [BE_W-1:0]   acc_be,
    input logic              req_valid,
    input logic [BUS_W-1:0]  req_bus,
    input logic [DEV_W-1:0]  req_dev,
    input logic [OFS_W-1:0]  req_reg,
    input logic [TYPE_W-1:0] req_type,
    input logic              req_unsupported,
    input logic              req_misaligned,
    input logic [BUS_W-1:0]  sec_q,
    input logic [BUS_W-1:0]  sub_q
);

    p_valid_next_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> req_valid);

    p_idle_next_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !req_valid);

    p_offset_copy_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (req_reg == $past(acc_addr[OFS_W-1:0])));

    p_type0_local_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type == TLP_CFG_T0) |-> (req_bus == $past(sec_q)));

    p_type1_range_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type == TLP_CFG_T1 && !req_unsupported)
        |-> (req_bus > $past(sec_q) && req_bus <= $past(sub_q)));

    p_type_code_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_type == TLP_CFG_T0 || req_type == TLP_CFG_T1));

    p_type0_dev_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type == TLP_CFG_T0 && !req_unsupported) |-> (req_dev == '0));

    p_misalign_cause_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_misaligned)
        |-> ((&$past(acc_be)) && $past(acc_addr[1:0]) != 2'b00));

endmodule

bind ecam_cfg_decoder ecam_cfg_checker chk_i (
    .clk             (clk),
    .rst             (rst),
    .acc_valid       (acc_valid),
    .acc_addr        (acc_addr),
    .acc_be          (acc_be),
    .req_valid       (req_valid),
    .req_bus         (req_bus),
    .req_dev         (req_dev),
    .req_reg         (req_reg),
    .req_type        (req_type),
    .req_unsupported (req_unsupported),
    .req_misaligned  (req_misaligned),
    .sec_q           (cfg_q.secondary),
    .sub_q           (cfg_q.subord)
);

// File: tb/ecam_cfg_decoder_tb.sv
module ecam_cfg_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [27:0] acc_addr = '0;
    logic [3:0]  acc_be = '0;
    logic        acc_write = 1'b0;
    logic        req_valid, req_write, req_unsupported, req_misaligned;
    logic [7:0]  req_bus;
    logic [4:0]  req_dev;
    logic [2:0]  req_func;
    logic [11:0] req_reg;
    logic [4:0]  req_type;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // behavioural model state
    int m_tgt = 0, m_msk = 255, m_sec = 0, m_sub = 0;

    always #2.5 clk = ~clk;

    ecam_cfg_decoder dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_be(acc_be), .acc_write(acc_write),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
        .req_type(req_type), .req_unsupported(req_unsupported),
        .req_misaligned(req_misaligned)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive write port and access, then compare against the model.
    task automatic step(input string tag, input bit wen, input int sel, input int wdata,
                        input bit av, input int bus_a, input int dev, input int fn,
                        input int ofs, input int be, input bit wr);
        int eff, ety, eun, emis;
        reg_wr_en   = wen;
        reg_wr_sel  = 2'(sel);
        reg_wr_data = 8'(wdata);
        acc_valid   = av;
        acc_addr    = {8'(bus_a), 5'(dev), 3'(fn), 12'(ofs)};
        acc_be      = 4'(be);
        acc_write   = wr;
        eff = (m_tgt & m_msk) | (bus_a & ~m_msk & 255);
        if (eff == m_sec) begin
            ety = 4; eun = (dev != 0) ? 1 : 0;
        end else begin
            ety = 5; eun = (eff > m_sec && eff <= m_sub) ? 0 : 1;
        end
        emis = (be == 15 && (ofs % 4) != 0) ? 1 : 0;
        @(posedge clk);
        if (wen) begin
            case (sel)
                0: m_tgt = wdata;
                1: m_msk = wdata;
                2: m_sec = wdata;
                default: m_sub = wdata;
            endcase
        end
        #1;
        check(tag, "valid", int'(req_valid), int'(av));
        if (av) begin
            check(tag, "bus", int'(req_bus), eff);
            check(tag, "dev", int'(req_dev), dev);
            check(tag, "func", int'(req_func), fn);
            check(tag, "reg", int'(req_reg), ofs);
            check(tag, "write", int'(req_write), int'(wr));
            check(tag, "type", int'(req_type), ety);
            check(tag, "unsupported", int'(req_unsupported), eun);
            check(tag, "misaligned", int'(req_misaligned), emis);
        end
        reg_wr_en = 1'b0;
        acc_valid = 1'b0;
    endtask

    task automatic wr(input string tag, input int sel, input int val);
        step(tag, 1, sel, val, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1", "valid after reset", int'(req_valid), 0);
        // R1: reset values -> any address bus maps to bus 0 = secondary, type 0
        step("R1", 0, 0, 0, 1, 8'h3C, 0, 0, 16, 15, 0);
        // R2: field extraction, read and write, idle cycle
        step("R2", 0, 0, 0, 1, 0, 0, 5, 12'hFFC, 15, 1);
        step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: type 0 to nonzero device
        step("R8", 0, 0, 0, 1, 0, 17, 2, 8, 15, 0);
        // set up hierarchy: secondary 5, subordinate 255
        wr("R4", 2, 5);
        wr("R10", 3, 255);
        // R3: mask all ones, target 9 -> type 1 in range
        wr("R3", 0, 9);
        step("R6", 0, 0, 0, 1, 8'h00, 3, 1, 4, 15, 0);
        // R3: mask zero -> address bits
        wr("R3", 1, 0);
        step("R3", 0, 0, 0, 1, 8'hA7, 1, 0, 0, 3, 1);
        step("R5", 0, 0, 0, 1, 5, 0, 7, 64, 15, 0);
        step("R7", 0, 0, 0, 1, 4, 0, 0, 0, 15, 0);
        step("R10", 0, 0, 0, 1, 255, 31, 7, 12'hFFC, 15, 0);
        // R3: mixed mask, high nibble from register
        wr("R3", 1, 8'hF0);
        wr("R3", 0, 8'h30);
        step("R3", 0, 0, 0, 1, 8'hC6, 2, 3, 12, 15, 0);
        // R4: write in same cycle as access uses old target
        step("R4", 1, 0, 8'h00, 1, 8'h05, 0, 0, 0, 15, 0);
        step("R4", 0, 0, 0, 1, 8'h05, 0, 0, 0, 15, 0);
        // R7: subordinate below bus
        wr("R7", 3, 20);
        wr("R7", 1, 0);
        step("R6", 0, 0, 0, 1, 20, 4, 0, 0, 15, 0);
        step("R7", 0, 0, 0, 1, 21, 4, 0, 0, 15, 0);
        step("R7", 0, 0, 0, 1, 200, 0, 0, 0, 15, 0);
        // R9: alignment patterns
        step("R9", 0, 0, 0, 1, 5, 0, 0, 1, 15, 0);
        step("R9", 0, 0, 0, 1, 5, 0, 0, 2, 15, 1);
        step("R9", 0, 0, 0, 1, 5, 0, 0, 3, 4'b1000, 0);
        step("R9", 0, 0, 0, 1, 5, 0, 0, 2, 4'b1100, 1);
        // R4: register holds across idle cycles
        step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 1, 12, 0, 1, 256, 15, 0);
        // R3: sweep of bus patterns against a mixed mask
        wr("R3", 1, 8'h5A);
        wr("R3", 0, 8'h0F);
        for (int i = 0; i < 32; i++) begin
            step("R3", 0, 0, 0, 1, (i * 37) % 256, i % 32, i % 8, (i * 4) % 4096, 15, i[0]);
        end
        // R5: secondary changed to 0, mask all ones, target 0
        wr("R5", 1, 255);
        wr("R5", 0, 0);
        wr("R5", 2, 0);
        step("R5", 0, 0, 0, 1, 99, 0, 0, 0, 15, 0);
        done = 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
    end

    initial begin
        wait (done || cycles > 5000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule